// File: doc/BRIEF.md
# Embedded Sync Video Stream Decoder

This block sits at the receive side of a 16-bit parallel digital video link. The link carries no separate sync wires. Each clock carries one word. In active regions the upper byte is luma and the lower byte is multiplexed Cb/Cr chroma, in 4:2:2 form. Timing is sent in-band as four-word reference sequences. The decoder finds these sequences, checks them, and rebuilds the field, vertical-blanking and horizontal-blanking flags. It also produces a data-valid strobe that marks the active samples of each visible line.

A reference sequence is one all-ones word, then two all-zero words, then a status word. The status byte is repeated in both halves of the word. Its bits, from MSB down, are a fixed 1, the field bit F, the vertical bit V, the horizontal bit H, and four protection bits. A status word with H=1 ends the active part of a line. It is followed by two words that carry the 11-bit line number. The decoder checks the protection bits, the preamble shape and the line-number framing. It raises a one-clock error pulse for each kind of fault and keeps its reported state unchanged when a fault is found.

Top module: `embsync_decoder`

## Requirements
- R1: After reset, and until the first valid reference sequence, every flag output, the strobe, every error pulse and the line number are 0.
- R2: A word 0xFFFF, then 0x0000, 0x0000, then a status word whose byte is {1,F,V,H,P3,P2,P1,P0} with correct protection bits, updates the field, vertical and horizontal outputs to F, V, H. The new values are visible on the clock edge that samples the status word.
- R3: The expected protection bits are P3=V^H, P2=F^H, P1=F^V and P0=F^V^H. On a mismatch the protection-error output pulses high for exactly the edge that samples the status word, and the three flags keep their values.
- R4: After a status word with H=0 and V=0, the strobe rises on the edge that samples the next word. The pixel output then equals that word. The strobe stays high for each following word until the edge that samples the next 0xFFFF word, which drives it low. It is never high on preamble, status or line-number words.
- R5: After a status word with V=1, following data words produce no strobe.
- R6: If an all-ones word is not followed by exactly two all-zero words, the preamble-error output pulses for one clock on the first wrong word. The flags are unchanged and the decoder searches for a new all-ones word.
- R7: A status word whose most significant bit (bit 7 of the byte) is 0 raises the preamble-error pulse and leaves the flags unchanged.
- R8: After a status word with H=1, the next word carries {~L6, L6..L0} and the one after carries {1,0,0,0, L10..L7}, each in both bytes. The line-number output takes {L10..L0} on the edge that samples the second word.
- R9: If bit 7 of the first line word does not equal the inverse of bit 6, or the upper nibble of the second line word is not 1000, the line-error output pulses for one clock on the second word and the line number is unchanged.
- R10: When the halves check is enabled (the default), a status word whose two bytes differ is treated as a protection error. A line word whose two bytes differ is treated as a line error.
- R11: Each error output is a single-clock pulse that is never high on two consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_in | input | 16 | Incoming stream word: luma in the upper byte, chroma in the lower byte |
| fld_o | output | 1 | Decoded field bit F |
| vblank_o | output | 1 | Decoded vertical-blanking bit V |
| hblank_o | output | 1 | Decoded horizontal bit H (1 after an end code) |
| pix_valid_o | output | 1 | High while pix_o holds an active sample |
| pix_o | output | 16 | Registered active sample word |
| line_o | output | 11 | Last correctly framed line number |
| prot_err_o | output | 1 | One-clock pulse on a protection-bit or status-halves mismatch |
| sync_err_o | output | 1 | One-clock pulse on a malformed preamble or a status fixed-bit fault |
| line_err_o | output | 1 | One-clock pulse on a malformed line-number pair |

## Verification
The assertions check several things on every cycle. The strobe is only high while both blanking flags are low. It is low after a status word and after an all-ones word in the search state. The flags do not move on an edge that reports a protection or preamble fault. The line number does not move on a line error. Every error output lasts a single clock. Only the bench's directed scenarios can show the exact cycle a flag or strobe changes, the pixel values passed through, the decoded line numbers such as 42 and 1121, and recovery to correct decoding after each kind of fault.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_ZERO1,
      ST_ZERO2,
      ST_STATUS,
      ST_LINE_LO,
      ST_LINE_HI
   } dec_state_t;

   // Expected protection nibble {P3,P2,P1,P0} for given F, V, H.
   function automatic logic [3:0] prot_calc(input logic f, input logic v, input logic h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/embsync_word_check.sv
module embsync_word_check #(
   parameter int BYTE_W       = 8,
   parameter bit CHECK_HALVES = 1'b1
) (
   input  logic [2*BYTE_W-1:0] word_i,
   output logic                all_ones_o,
   output logic                all_zero_o,
   output logic                halves_ok_o,
   output logic [BYTE_W-1:0]   low_byte_o
);
   localparam int WORD_W = 2 * BYTE_W;

   assign all_ones_o = (word_i == {WORD_W{1'b1}});
   assign all_zero_o = (word_i == {WORD_W{1'b0}});
   assign low_byte_o = word_i[BYTE_W-1:0];

   generate
      if (CHECK_HALVES) begin : g_halves_cmp
         assign halves_ok_o = (word_i[WORD_W-1:BYTE_W] == word_i[BYTE_W-1:0]);
      end else begin : g_halves_skip
         assign halves_ok_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/embsync_trs_fsm.sv
module embsync_trs_fsm
   import embsync_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*BYTE_W-1:0] word_i,
   input  logic                all_ones_i,
   input  logic                all_zero_i,
   input  logic                halves_ok_i,
   input  logic [BYTE_W-1:0]   low_byte_i,
   output logic                fld_o,
   output logic                vbl_o,
   output logic                hbl_o,
   output logic                de_o,
   output logic [2*BYTE_W-1:0] pix_o,
   output logic                sync_err_o,
   output logic                prot_err_o,
   output logic                lo_stb_o,
   output logic                hi_stb_o
);
   localparam int MSB_POS = BYTE_W - 1;
   localparam int F_POS   = BYTE_W - 2;
   localparam int V_POS   = BYTE_W - 3;
   localparam int H_POS   = BYTE_W - 4;

   dec_state_t state_q;
   logic       run_q;
   logic       rx_f, rx_v, rx_h;
   logic [3:0] rx_prot;
   logic       prot_ok;

   assign rx_f    = low_byte_i[F_POS];
   assign rx_v    = low_byte_i[V_POS];
   assign rx_h    = low_byte_i[H_POS];
   assign rx_prot = low_byte_i[3:0];
   assign prot_ok = (rx_prot == prot_calc(rx_f, rx_v, rx_h)) && halves_ok_i;

   assign lo_stb_o = (state_q == ST_LINE_LO);
   assign hi_stb_o = (state_q == ST_LINE_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_HUNT;
         run_q      <= 1'b0;
         fld_o      <= 1'b0;
         vbl_o      <= 1'b0;
         hbl_o      <= 1'b0;
         de_o       <= 1'b0;
         pix_o      <= '0;
         sync_err_o <= 1'b0;
         prot_err_o <= 1'b0;
      end else begin
         sync_err_o <= 1'b0;
         prot_err_o <= 1'b0;
         de_o       <= 1'b0;
         unique case (state_q)
            ST_HUNT: begin
               if (all_ones_i) begin
                  run_q   <= 1'b0;
                  state_q <= ST_ZERO1;
               end else if (run_q) begin
                  de_o  <= 1'b1;
                  pix_o <= word_i;
               end
            end
            ST_ZERO1: begin
               if (all_zero_i) begin
                  state_q <= ST_ZERO2;
               end else begin
                  sync_err_o <= 1'b1;
                  state_q    <= ST_HUNT;
               end
            end
            ST_ZERO2: begin
               if (all_zero_i) begin
                  state_q <= ST_STATUS;
               end else begin
                  sync_err_o <= 1'b1;
                  state_q    <= ST_HUNT;
               end
            end
            ST_STATUS: begin
               if (!low_byte_i[MSB_POS]) begin
                  sync_err_o <= 1'b1;
                  state_q    <= ST_HUNT;
               end else if (!prot_ok) begin
                  prot_err_o <= 1'b1;
                  state_q    <= ST_HUNT;
               end else begin
                  fld_o <= rx_f;
                  vbl_o <= rx_v;
                  hbl_o <= rx_h;
                  if (rx_h) begin
                     state_q <= ST_LINE_LO;
                  end else begin
                     run_q   <= !rx_v;
                     state_q <= ST_HUNT;
                  end
               end
            end
            ST_LINE_LO: state_q <= ST_LINE_HI;
            ST_LINE_HI: state_q <= ST_HUNT;
            default:    state_q <= ST_HUNT;
         endcase
      end
   end

   // R4: strobe only inside an active region
   p_de_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      de_o |-> (!vbl_o && !hbl_o));
   // R4: an all-ones word while searching ends the strobe
   p_de_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HUNT && all_ones_i) |=> !de_o);
   // R4: no strobe on a status word
   p_no_de_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STATUS) |=> !de_o);
   // R3: flags held on a protection fault
   p_prot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prot_err_o |-> $stable({fld_o, vbl_o, hbl_o}));
   // R6: flags held on a preamble fault
   p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err_o |-> $stable({fld_o, vbl_o, hbl_o}));
   // R11: single-cycle error pulses
   p_sync_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err_o |=> !sync_err_o);
   p_prot_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      prot_err_o |=> !prot_err_o);

endmodule

// File: rtl/embsync_line_capture.sv
module embsync_line_capture #(
   parameter int BYTE_W = 8,
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_stb_i,
   input  logic              hi_stb_i,
   input  logic              halves_ok_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [LINE_W-1:0] line_o,
   output logic              line_err_o
);
   localparam int LO_W  = BYTE_W - 1;
   localparam int HI_W  = LINE_W - LO_W;
   localparam int TAG_W = BYTE_W - HI_W;
   localparam logic [TAG_W-1:0] HI_TAG = TAG_W'(1) << (TAG_W - 1);

   generate
      if (HI_W < 1 || TAG_W < 2) begin : g_bad_split
         $error("line width does not fit the two line words");
      end
   endgenerate

   logic [LO_W-1:0] lo_q;
   logic            lo_bad_q;
   logic            hi_bad;

   assign hi_bad = (byte_i[BYTE_W-1:HI_W] != HI_TAG) || !halves_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q       <= '0;
         lo_bad_q   <= 1'b0;
         line_o     <= '0;
         line_err_o <= 1'b0;
      end else begin
         line_err_o <= 1'b0;
         if (lo_stb_i) begin
            lo_q     <= byte_i[LO_W-1:0];
            lo_bad_q <= (byte_i[BYTE_W-1] == byte_i[BYTE_W-2]) || !halves_ok_i;
         end
         if (hi_stb_i) begin
            if (lo_bad_q || hi_bad) begin
               line_err_o <= 1'b1;
            end else begin
               line_o <= {byte_i[HI_W-1:0], lo_q};
            end
         end
      end
   end

   // R9: line number held on a framing fault
   p_line_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_err_o |-> $stable(line_o));
   // R11: single-cycle line error
   p_line_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      line_err_o |=> !line_err_o);
   // R8: line number only moves on the second line word
   p_line_when_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hi_stb_i) |-> $stable(line_o));

endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder #(
   parameter int BYTE_W       = 8,
   parameter int LINE_W       = 11,
   parameter bit CHECK_HALVES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*BYTE_W-1:0] vid_in,
   output logic                fld_o,
   output logic                vblank_o,
   output logic                hblank_o,
   output logic                pix_valid_o,
   output logic [2*BYTE_W-1:0] pix_o,
   output logic [LINE_W-1:0]   line_o,
   output logic                prot_err_o,
   output logic                sync_err_o,
   output logic                line_err_o
);
   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("status byte layout needs BYTE_W of 8");
      end
   endgenerate

   logic              all_ones, all_zero, halves_ok;
   logic [BYTE_W-1:0] low_byte;
   logic              lo_stb, hi_stb;

   embsync_word_check #(
      .BYTE_W      (BYTE_W),
      .CHECK_HALVES(CHECK_HALVES)
   ) u_check (
      .word_i     (vid_in),
      .all_ones_o (all_ones),
      .all_zero_o (all_zero),
      .halves_ok_o(halves_ok),
      .low_byte_o (low_byte)
   );

   embsync_trs_fsm #(
      .BYTE_W(BYTE_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_i     (vid_in),
      .all_ones_i (all_ones),
      .all_zero_i (all_zero),
      .halves_ok_i(halves_ok),
      .low_byte_i (low_byte),
      .fld_o      (fld_o),
      .vbl_o      (vblank_o),
      .hbl_o      (hblank_o),
      .de_o       (pix_valid_o),
      .pix_o      (pix_o),
      .sync_err_o (sync_err_o),
      .prot_err_o (prot_err_o),
      .lo_stb_o   (lo_stb),
      .hi_stb_o   (hi_stb)
   );

   embsync_line_capture #(
      .BYTE_W(BYTE_W),
      .LINE_W(LINE_W)
   ) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .lo_stb_i   (lo_stb),
      .hi_stb_i   (hi_stb),
      .halves_ok_i(halves_ok),
      .byte_i     (low_byte),
      .line_o     (line_o),
      .line_err_o (line_err_o)
   );

endmodule

// File: tb/embsync_decoder_test.sv
module embsync_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] vid_in = 16'h1080;
   logic        fld_o, vblank_o, hblank_o, pix_valid_o;
   logic [15:0] pix_o;
   logic [10:0] line_o;
   logic        prot_err_o, sync_err_o, line_err_o;
   int          n_checks = 0;
   int          n_errors = 0;

   always #5 clk = ~clk;

   embsync_decoder uut (
      .clk(clk), .rst_n(rst_n), .vid_in(vid_in),
      .fld_o(fld_o), .vblank_o(vblank_o), .hblank_o(hblank_o),
      .pix_valid_o(pix_valid_o), .pix_o(pix_o), .line_o(line_o),
      .prot_err_o(prot_err_o), .sync_err_o(sync_err_o), .line_err_o(line_err_o)
   );

   function automatic logic [7:0] sbyte(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction
   function automatic logic [15:0] stat(input logic f, input logic v, input logic h);
      return {sbyte(f, v, h), sbyte(f, v, h)};
   endfunction
   function automatic logic [7:0] lb1(input logic [10:0] n);
      return {~n[6], n[6:0]};
   endfunction
   function automatic logic [15:0] lw1(input logic [10:0] n);
      return {lb1(n), lb1(n)};
   endfunction
   function automatic logic [15:0] lw2(input logic [10:0] n);
      return {4'b1000, n[10:7], 4'b1000, n[10:7]};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [15:0] w);
      @(negedge clk);
      vid_in = w;
      @(posedge clk);
      #2;
   endtask

   task automatic pre();
      put(16'hFFFF);
      chk("R4", "no strobe on ones word", pix_valid_o, 0);
      put(16'h0000);
      chk("R4", "no strobe on zero word", pix_valid_o, 0);
      put(16'h0000);
   endtask

   task automatic t_reset();
      chk("R1", "flags", {fld_o, vblank_o, hblank_o}, 0);
      chk("R1", "strobe", pix_valid_o, 0);
      chk("R1", "errors", {prot_err_o, sync_err_o, line_err_o}, 0);
      chk("R1", "line", line_o, 0);
      put(16'h1234);
      chk("R1", "no strobe before sync", pix_valid_o, 0);
   endtask

   task automatic t_active();
      pre();
      put(stat(0, 0, 0));
      chk("R2", "flags after start code", {fld_o, vblank_o, hblank_o}, 3'b000);
      chk("R4", "no strobe on status", pix_valid_o, 0);
      put(16'h5A80);
      chk("R4", "strobe first sample", pix_valid_o, 1);
      chk("R4", "pixel first sample", pix_o, 16'h5A80);
      put(16'h2233);
      chk("R4", "pixel second sample", pix_o, 16'h2233);
      pre();
      chk("R4", "strobe low in preamble", pix_valid_o, 0);
      put(stat(0, 0, 1));
      chk("R2", "end code sets H", {fld_o, vblank_o, hblank_o}, 3'b001);
      put(lw1(11'd42));
      chk("R4", "no strobe on line word", pix_valid_o, 0);
      put(lw2(11'd42));
      chk("R8", "line 42", line_o, 42);
      chk("R9", "no line error", line_err_o, 0);
   endtask

   task automatic t_vblank();
      pre();
      put(stat(0, 1, 0));
      chk("R2", "V set", {fld_o, vblank_o, hblank_o}, 3'b010);
      put(16'h1234);
      chk("R5", "no strobe in vblank", pix_valid_o, 0);
      put(16'h1080);
      chk("R5", "still no strobe", pix_valid_o, 0);
   endtask

   task automatic t_field();
      pre();
      put(stat(1, 0, 0));
      chk("R2", "F set", {fld_o, vblank_o, hblank_o}, 3'b100);
      put(16'hEB80);
      chk("R4", "strobe field 1", pix_valid_o, 1);
      pre();
      put(stat(1, 0, 1));
      put(lw1(11'd1121));
      put(lw2(11'd1121));
      chk("R8", "line 1121", line_o, 1121);
   endtask

   task automatic t_parity();
      pre();
      put(stat(0, 1, 0) ^ 16'h0101);
      chk("R3", "protection error", prot_err_o, 1);
      chk("R3", "flags held", {fld_o, vblank_o, hblank_o}, 3'b101);
      put(16'h1080);
      chk("R11", "protection pulse ends", prot_err_o, 0);
      chk("R3", "no strobe after bad code", pix_valid_o, 0);
   endtask

   task automatic t_preamble();
      put(16'hFFFF);
      put(16'h0000);
      put(16'h0500);
      chk("R6", "preamble error", sync_err_o, 1);
      chk("R6", "flags held", {fld_o, vblank_o, hblank_o}, 3'b101);
      put(16'h1080);
      chk("R11", "preamble pulse ends", sync_err_o, 0);
      put(16'hFFFF);
      put(16'h0700);
      chk("R6", "error on first zero slot", sync_err_o, 1);
      pre();
      put(stat(0, 0, 0));
      chk("R6", "recovers after fault", {fld_o, vblank_o, hblank_o}, 3'b000);
      pre();
      put(16'h7070);
      chk("R7", "fixed bit fault", sync_err_o, 1);
      chk("R7", "flags held", {fld_o, vblank_o, hblank_o}, 3'b000);
      put(16'h1234);
      chk("R7", "no strobe after fixed bit fault", pix_valid_o, 0);
   endtask

   task automatic t_line_err();
      pre();
      put(stat(0, 0, 1));
      put(lw1(11'd42) ^ 16'h8080);
      put(lw2(11'd42));
      chk("R9", "marker bit error", line_err_o, 1);
      chk("R9", "line held", line_o, 1121);
      put(16'h1080);
      chk("R11", "line pulse ends", line_err_o, 0);
      pre();
      put(stat(0, 0, 1));
      put(lw1(11'd100));
      put(lw2(11'd100) ^ 16'h4040);
      chk("R9", "tag nibble error", line_err_o, 1);
      chk("R9", "line held after tag fault", line_o, 1121);
      pre();
      put(stat(0, 0, 1));
      put(lw1(11'd5));
      put(lw2(11'd5));
      chk("R8", "line 5", line_o, 5);
   endtask

   task automatic t_halves();
      pre();
      put({sbyte(0, 1, 0), sbyte(0, 0, 0)});
      chk("R10", "status halves differ", prot_err_o, 1);
      chk("R10", "flags held", {fld_o, vblank_o, hblank_o}, 3'b001);
      pre();
      put(stat(0, 0, 1));
      put({lb1(11'd7), lb1(11'd8)});
      put(lw2(11'd7));
      chk("R10", "line halves differ", line_err_o, 1);
      chk("R10", "line held", line_o, 5);
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      t_reset_pre();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_active();
      t_vblank();
      t_field();
      t_parity();
      t_preamble();
      t_line_err();
      t_halves();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   task automatic t_reset_pre();
      chk("R1", "strobe in reset", pix_valid_o, 0);
      chk("R1", "line in reset", line_o, 0);
   endtask

endmodule